// File: doc/BRIEF.md
# Zero-Overhead Block Repeat Controller

This block steers the program counter of a small signal-processing core around hardware loops. A begin-repeat strobe claims a free loop level, loads that level's 8-bit repeat count, clears its index register and records the address that follows the begin instruction. A return strobe names one loop level. If that level's index has not yet reached the last pass, the block sends the PC back to the loop top and advances the index. Otherwise the PC falls through and the level is released.

The branch decision is combinational from the decoded strobes to `next_pc`, so it takes effect in the same cycle the return instruction is decoded. A taken loop-back therefore costs no extra cycle and needs no NOP slot. There are two independent levels, which allows one loop to be nested inside another. The return target is either the label carried by the instruction or the start address the level recorded, as the instruction selects.

Top module: `hwloop_ctrl`

## Requirements
- R1: After reset, `loop_active` is 0, both index fields of `loop_idx` read 0, `nest_ovf` is 0, and with no strobe asserted `next_pc` equals `seq_pc`.
- R2: A `rpt_begin` claims the lowest-numbered inactive level. From the next cycle that level's bit in `loop_active` is 1 and its index reads 0. During the begin cycle `next_pc` equals `seq_pc`.
- R3: A `rpt_ret` naming an active level with index i and count N, where i+1 < N, sets `next_pc` to the target in that same cycle, and the index reads i+1 on the next cycle.
- R4: A `rpt_ret` naming an active level whose index i satisfies i+1 >= N sets `next_pc` to `seq_pc` and releases the level on the next cycle, leaving its index unchanged. A count N therefore gives max(N,1) passes through the body; a count of 255 gives passes 0 through 254.
- R5: The branch target is `ret_label` when `ret_to_start` is 0. When `ret_to_start` is 1, the target is the `seq_pc` value that was present when the named level was claimed.
- R6: A `rpt_ret` naming an inactive level leaves `next_pc` equal to `seq_pc` and changes no index or active bit.
- R7: A `rpt_begin` while every level is active changes no level state, and `nest_ovf` is 1 on exactly the next cycle only.
- R8: The levels are independent. A return naming one level changes neither the index nor the active bit of the other level.
- R9: When `rpt_begin` and `rpt_ret` are both asserted in one cycle, the return is ignored and `next_pc` equals `seq_pc`. The begin still takes effect.
- R10: `ret_sel` selects the level by number: 0 names level 0 (`loop_idx[7:0]`) and 1 names level 1 (`loop_idx[15:8]`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rpt_begin | input | 1 | Decoded begin-repeat strobe |
| rpt_count | input | 8 | Repeat count loaded on begin |
| rpt_ret | input | 1 | Decoded return-from-block strobe |
| ret_sel | input | 1 | Level named by the return |
| ret_to_start | input | 1 | 1: branch to the recorded start address; 0: branch to the label |
| ret_label | input | 12 | Label address carried by the return |
| seq_pc | input | 12 | Sequential next PC of the current instruction |
| next_pc | output | 12 | PC to fetch next |
| loop_active | output | 2 | One bit per level, 1 while that level is running |
| loop_idx | output | 16 | Index registers, level 0 in bits 7:0 |
| nest_ovf | output | 1 | One-cycle flag: a begin was refused because every level was active |

## Verification
The bench builds the block with its default values: two levels, 8-bit counts and a 12-bit PC. This keeps the whole count range within reach. A single-level sweep covers counts 0 through 12 plus 255, with the target source alternating between label and start address. A nested sweep crosses outer counts 1 to 3 with inner counts 0 to 4. Two levels also make it cheap to reach the full-nesting refusal, allocation back into level 0 while level 1 is still running, and a begin and a return arriving in the same cycle.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
    localparam int DEF_LEVELS = 2;
    localparam int DEF_CNT_W  = 8;
    localparam int DEF_PC_W   = 12;

    typedef enum logic [1:0] {
        SRC_SEQ   = 2'd0,
        SRC_LABEL = 2'd1,
        SRC_START = 2'd2
    } pc_src_e;
endpackage

// File: rtl/hwloop_alloc.sv
module hwloop_alloc #(
    parameter int NUM_LEVELS = 2
) (
    input  logic                  begin_i,
    input  logic [NUM_LEVELS-1:0] active_i,
    output logic [NUM_LEVELS-1:0] grant_o,
    output logic                  full_o
);
    logic found;

    always_comb begin
        grant_o = '0;
        found   = 1'b0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (!found && !active_i[i]) begin
                grant_o[i] = begin_i;
                found      = 1'b1;
            end
        end
        full_o = !found;
    end

    // R2: at most one level is claimed per begin
    assert_one_grant_R2: assert final ($onehot0(grant_o));
endmodule

// File: rtl/hwloop_level.sv
module hwloop_level #(
    parameter int CNT_W = 8,
    parameter int PC_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [PC_W-1:0]  start_i,
    input  logic             step_i,
    output logic             active_o,
    output logic [CNT_W-1:0] idx_o,
    output logic [PC_W-1:0]  start_o,
    output logic             taken_o
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] rc;
        logic [CNT_W-1:0] idx;
        logic [PC_W-1:0]  start;
    } lvl_t;

    lvl_t           st_d, st_q;
    logic [CNT_W:0] idx_inc;
    logic           more;

    always_comb begin
        idx_inc = {1'b0, st_q.idx} + {{CNT_W{1'b0}}, 1'b1};
        more    = idx_inc < {1'b0, st_q.rc};
        taken_o = step_i && st_q.active && more;
        st_d    = st_q;
        if (load_i) begin
            st_d.active = 1'b1;
            st_d.rc     = count_i;
            st_d.idx    = '0;
            st_d.start  = start_i;
        end else if (step_i && st_q.active) begin
            if (more) begin
                st_d.idx = idx_inc[CNT_W-1:0];
            end else begin
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
    assign idx_o    = st_q.idx;
    assign start_o  = st_q.start;

    // R2: a claimed level starts at index 0
    assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (active_o && idx_o == '0));
    // R3: the index stays below a nonzero count while running
    assert_idx_below_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.rc != '0) |-> (st_q.idx < st_q.rc));
    // R4: a fall-through return releases the level and keeps the index
    assert_exit_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && active_o && !taken_o) |=> (!active_o && $stable(idx_o)));
    // R6: a return on an idle level does nothing
    assert_idle_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !active_o) |=> (!active_o && $stable(idx_o)));
endmodule

// File: rtl/hwloop_target.sv
module hwloop_target
    import hwloop_pkg::*;
#(
    parameter int NUM_LEVELS = 2,
    parameter int PC_W       = 12
) (
    input  logic [NUM_LEVELS-1:0]      taken_i,
    input  logic                       to_start_i,
    input  logic [NUM_LEVELS*PC_W-1:0] starts_i,
    input  logic [PC_W-1:0]            label_i,
    input  logic [PC_W-1:0]            seq_i,
    output logic [PC_W-1:0]            next_pc_o
);
    pc_src_e         src;
    logic [PC_W-1:0] start_sel;

    always_comb begin
        start_sel = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (taken_i[i]) begin
                start_sel = starts_i[i*PC_W +: PC_W];
            end
        end
        if (taken_i == '0) begin
            src = SRC_SEQ;
        end else if (to_start_i) begin
            src = SRC_START;
        end else begin
            src = SRC_LABEL;
        end
        case (src)
            SRC_LABEL: next_pc_o = label_i;
            SRC_START: next_pc_o = start_sel;
            default:   next_pc_o = seq_i;
        endcase
    end
endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int NUM_LEVELS = DEF_LEVELS,
    parameter int CNT_W      = DEF_CNT_W,
    parameter int PC_W       = DEF_PC_W,
    localparam int SEL_W     = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rpt_begin,
    input  logic [CNT_W-1:0]            rpt_count,
    input  logic                        rpt_ret,
    input  logic [SEL_W-1:0]            ret_sel,
    input  logic                        ret_to_start,
    input  logic [PC_W-1:0]             ret_label,
    input  logic [PC_W-1:0]             seq_pc,
    output logic [PC_W-1:0]             next_pc,
    output logic [NUM_LEVELS-1:0]       loop_active,
    output logic [NUM_LEVELS*CNT_W-1:0] loop_idx,
    output logic                        nest_ovf
);
    logic [NUM_LEVELS-1:0]      grant;
    logic [NUM_LEVELS-1:0]      step;
    logic [NUM_LEVELS-1:0]      taken;
    logic [NUM_LEVELS*PC_W-1:0] starts;
    logic                       full;
    logic                       ovf_d, ovf_q;

    hwloop_alloc #(.NUM_LEVELS(NUM_LEVELS)) u_alloc (
        .begin_i  (rpt_begin),
        .active_i (loop_active),
        .grant_o  (grant),
        .full_o   (full)
    );

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_level
        assign step[g] = rpt_ret && !rpt_begin && (ret_sel == SEL_W'(g));

        hwloop_level #(.CNT_W(CNT_W), .PC_W(PC_W)) u_level (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (grant[g]),
            .count_i  (rpt_count),
            .start_i  (seq_pc),
            .step_i   (step[g]),
            .active_o (loop_active[g]),
            .idx_o    (loop_idx[g*CNT_W +: CNT_W]),
            .start_o  (starts[g*PC_W +: PC_W]),
            .taken_o  (taken[g])
        );
    end

    hwloop_target #(.NUM_LEVELS(NUM_LEVELS), .PC_W(PC_W)) u_target (
        .taken_i    (taken),
        .to_start_i (ret_to_start),
        .starts_i   (starts),
        .label_i    (ret_label),
        .seq_i      (seq_pc),
        .next_pc_o  (next_pc)
    );

    always_comb begin
        ovf_d = rpt_begin && full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= ovf_d;
        end
    end

    assign nest_ovf = ovf_q;

    // R7: a refused begin raises the flag on the next cycle and keeps the levels
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_begin && (&loop_active)) |=> (nest_ovf && (&loop_active) && $stable(loop_idx)));
    // R7: the flag lasts a single cycle unless refused again
    assert_ovf_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rpt_begin && (&loop_active)) |=> !nest_ovf);
    // R9: a begin in the same cycle masks the return
    assert_begin_masks_ret_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_begin |-> (next_pc == seq_pc));
    // R6: a return on an idle level falls through
    assert_idle_ret_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_ret && !rpt_begin && !loop_active[ret_sel]) |-> (next_pc == seq_pc));
endmodule

// File: tb/tb_hwloop_ctrl.sv
`timescale 1ns/1ps
module tb_hwloop_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rpt_begin = 1'b0;
    logic [7:0]  rpt_count = '0;
    logic        rpt_ret = 1'b0;
    logic [0:0]  ret_sel = '0;
    logic        ret_to_start = 1'b0;
    logic [11:0] ret_label = '0;
    logic [11:0] seq_pc = '0;
    logic [11:0] next_pc;
    logic [1:0]  loop_active;
    logic [15:0] loop_idx;
    logic        nest_ovf;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_act [2];
    int          m_cnt [2];
    int          m_idx [2];
    logic [11:0] m_start [2];
    logic [11:0] pc_cnt = 12'h100;
    bit          last_taken;

    always #2.5 clk = ~clk;

    hwloop_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rpt_begin(rpt_begin), .rpt_count(rpt_count),
        .rpt_ret(rpt_ret), .ret_sel(ret_sel), .ret_to_start(ret_to_start),
        .ret_label(ret_label), .seq_pc(seq_pc), .next_pc(next_pc),
        .loop_active(loop_active), .loop_idx(loop_idx), .nest_ovf(nest_ovf)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic b, input int n, input logic r, input int s,
                        input logic [11:0] lbl, input logic ts, input string tag);
        logic [11:0] exp_pc;
        logic        exp_ovf;
        int          free;
        @(negedge clk);
        rpt_begin = b; rpt_count = n[7:0]; rpt_ret = r; ret_sel = s[0:0];
        ret_label = lbl; ret_to_start = ts; seq_pc = pc_cnt;
        #1;
        exp_pc = pc_cnt;
        exp_ovf = 1'b0;
        if (b) begin
            free = -1;
            for (int i = 1; i >= 0; i--) if (!m_act[i]) free = i;
            if (free < 0) exp_ovf = 1'b1;
            else begin
                m_act[free] = 1'b1; m_cnt[free] = n; m_idx[free] = 0;
                m_start[free] = pc_cnt;
            end
        end else if (r && m_act[s]) begin
            if (m_idx[s] + 1 < m_cnt[s]) begin
                exp_pc = ts ? m_start[s] : lbl;
                m_idx[s]++;
            end else begin
                m_act[s] = 1'b0;
            end
        end
        last_taken = (exp_pc != pc_cnt);
        chk(next_pc === exp_pc, tag, "next_pc", int'(next_pc), int'(exp_pc));
        @(posedge clk);
        #1;
        chk(loop_active === {m_act[1], m_act[0]}, tag, "loop_active",
            int'(loop_active), int'({m_act[1], m_act[0]}));
        chk(loop_idx[7:0] === m_idx[0][7:0], tag, "idx0", int'(loop_idx[7:0]), m_idx[0]);
        chk(loop_idx[15:8] === m_idx[1][7:0], tag, "idx1", int'(loop_idx[15:8]), m_idx[1]);
        chk(nest_ovf === exp_ovf, tag, "nest_ovf", int'(nest_ovf), int'(exp_ovf));
        rpt_begin = 1'b0; rpt_ret = 1'b0;
        pc_cnt = pc_cnt + 12'd3;
    endtask

    initial begin
        int passes;
        int guard;
        for (int i = 0; i < 2; i++) begin
            m_act[i] = 0; m_cnt[i] = 0; m_idx[i] = 0; m_start[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(loop_active === 2'b00, "R1", "loop_active", int'(loop_active), 0);
        chk(loop_idx === 16'h0, "R1", "loop_idx", int'(loop_idx), 0);
        chk(nest_ovf === 1'b0, "R1", "nest_ovf", int'(nest_ovf), 0);
        step(0, 0, 0, 0, 12'h040, 0, "R1");

        // R6: return on an idle level
        step(0, 0, 1, 1, 12'h040, 0, "R6");
        step(0, 0, 1, 0, 12'h040, 1, "R6");

        // R2 R3 R4 R5: single-level sweep of counts
        for (int n = 0; n <= 13; n++) begin
            int cnt;
            cnt = (n == 13) ? 255 : n;
            step(1, cnt, 0, 0, 12'h000, 0, "R2");
            passes = 1;
            guard = 0;
            while (m_act[0] && guard < 300) begin
                step(0, 0, 1, 0, 12'h040 + 12'(n), n[0], n[0] ? "R5" : "R3");
                if (last_taken) passes++;
                guard++;
            end
            chk(passes == ((cnt < 1) ? 1 : cnt), "R4", "passes", passes,
                (cnt < 1) ? 1 : cnt);
        end

        // R8 R10: nested sweep
        for (int n0 = 1; n0 <= 3; n0++) begin
            for (int n1 = 0; n1 <= 4; n1++) begin
                step(1, n0, 0, 0, 12'h0, 0, "R2");
                guard = 0;
                while (m_act[0] && guard < 100) begin
                    step(1, n1, 0, 0, 12'h0, 0, "R10");
                    while (m_act[1] && guard < 100) begin
                        step(0, 0, 1, 1, 12'h200, 0, "R8");
                        guard++;
                    end
                    step(0, 0, 1, 0, 12'h300, 1, "R10");
                    guard++;
                end
            end
        end

        // R7: full nesting refuses a begin
        step(1, 5, 0, 0, 12'h0, 0, "R2");
        step(1, 4, 0, 0, 12'h0, 0, "R2");
        step(0, 0, 1, 1, 12'h210, 0, "R8");
        step(1, 9, 0, 0, 12'h0, 0, "R7");
        step(0, 0, 0, 0, 12'h0, 0, "R7");
        // R2: level 0 released while level 1 runs; next begin claims level 0
        for (int k = 0; k < 5; k++) step(0, 0, 1, 0, 12'h220, 0, "R4");
        step(1, 2, 0, 0, 12'h0, 0, "R2");
        // R9: begin and return together, return masked
        for (int k = 0; k < 4; k++) step(0, 0, 1, 1, 12'h230, 0, "R4");
        step(1, 3, 1, 0, 12'h240, 0, "R9");
        step(0, 0, 1, 1, 12'h250, 0, "R3");
        step(0, 0, 1, 0, 12'h260, 0, "R4");
        step(0, 0, 1, 1, 12'h270, 1, "R5");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule